// File: doc/BRIEF.md
# Descriptor-Delimited Multi-Channel Frame Assembler

The block keeps one byte buffer per DMA channel. Payload is delivered as memory-write requests, each naming a channel, a byte address inside that channel's buffer and one data word. The writes may arrive in any address order, and they say nothing about where a frame begins or ends.

A frame exists only once a descriptor is posted for it. The descriptor names the channel, the byte address of the first byte, the length in bytes and an opaque metadata field. Descriptors wait in a short queue and are served in arrival order. For each one the block reads the channel buffer at consecutive word addresses, wrapping at the end of the buffer. It sends the words out on a single-region valid/ready stream with start and end markers, a last-byte position and a sideband that carries size, channel and metadata.

A descriptor with a length of zero, or a length above the configured maximum, is discarded without output and raises a sticky error flag. One packet counter per channel counts the frames that have been delivered.

Top module: `chan_frame_assembler`

## Requirements
- R1: After reset, `out_valid`, `err_sticky` and every packet counter are 0, and `dsc_ready` is 1.
- R2: Words written in any address order are emitted in ascending address order, starting at the word that holds the descriptor's start address. Buffer byte `4*w+i` is `out_data[8*i+7:8*i]`. The two low address bits are ignored, on writes and on descriptors alike.
- R3: A frame of `n` bytes is emitted as `ceil(n/4)` beats. `out_sof` is 1 only on the first beat and `out_eof` is 1 only on the last. On the last beat `out_eof_pos` equals `(n-1) mod 4`.
- R4: `out_size`, `out_chan` and `out_meta` equal the descriptor's length, channel and metadata on every beat of the frame.
- R5: While `out_valid` is 1 and `out_ready` is 0, every output stays unchanged on the next cycle and `out_valid` stays 1.
- R6: Frames leave in descriptor order and never interleave. A start-of-frame appears only after the previous frame's end beat has been transferred.
- R7: Reads wrap modulo the buffer size of `2**PTR_W` bytes. A frame that runs past the top of the buffer continues at address 0.
- R8: A request with `wr_is_write`=0 leaves the buffer contents unchanged.
- R9: A descriptor whose length is 0 or greater than `MAX_BYTES` (1024) produces no output beat and sets `err_sticky`. `err_sticky` stays 1 until reset.
- R10: The packet counter of channel `c` (`pkt_cnt[c*CNT_W +: CNT_W]`) increases by exactly 1 on each transferred end beat of channel `c`, and in no other cycle.
- R11: A write to one channel never changes the data read for another channel at the same address.
- R12: `dsc_ready` is 0 while the queue holds `FIFO_DEPTH` entries, and an offered descriptor is then not taken. With the output stalled, exactly `FIFO_DEPTH+1` descriptors are accepted: one in service plus a full queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Request valid |
| wr_is_write | input | 1 | 1 = memory write, 0 = read request (ignored) |
| wr_chan | input | CH_W | Target channel |
| wr_addr | input | PTR_W | Byte address inside the channel buffer |
| wr_data | input | DATA_W | Data word |
| dsc_valid | input | 1 | Descriptor valid |
| dsc_ready | output | 1 | Descriptor queue has room |
| dsc_chan | input | CH_W | Frame channel |
| dsc_addr | input | PTR_W | Byte address of the first frame byte |
| dsc_size | input | SIZE_W | Frame length in bytes |
| dsc_meta | input | META_W | Opaque frame metadata |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink accepts beat |
| out_data | output | DATA_W | Beat data |
| out_sof | output | 1 | First beat of a frame |
| out_eof | output | 1 | Last beat of a frame |
| out_eof_pos | output | WBW | Index of last valid byte in the end beat |
| out_size | output | SIZE_W | Frame length sideband |
| out_chan | output | CH_W | Frame channel sideband |
| out_meta | output | META_W | Frame metadata sideband |
| err_sticky | output | 1 | A descriptor with an illegal length was dropped |
| pkt_cnt | output | CHANNELS*CNT_W | Per-channel delivered-frame counters |

## Verification
The embedded properties check the following on every cycle: output stability under backpressure, start/end framing with no interleave, constant sideband within a frame, stickiness of the error flag, the queue bound and the exact step of each packet counter. The bench scenarios have to show the rest, since these facts depend on what was stored earlier. They cover reordering of scattered writes into address order, wrap-around at the buffer top, read requests that leave data untouched, channel isolation, dropped illegal descriptors and the exact number of descriptors accepted while the output is stalled.

// File: rtl/frame_asm_pkg.sv
package frame_asm_pkg;

    // Read engine phase
    typedef enum logic [0:0] {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_e;

endpackage

// File: rtl/fa_desc_fifo.sv
module fa_desc_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] slot_q [DEPTH];
    logic [IDX_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;

    logic do_push, do_pop;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = slot_q[rd_q];

    function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= nxt(wr_q);
            if (do_pop)  rd_q <= nxt(rd_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) slot_q[wr_q] <= din;
    end

    // R12: occupancy never exceeds the configured depth
    a_r12_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH));

    // R12: a push offered while full leaves the occupancy unchanged unless popped
    a_r12_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
        push && full && !pop |=> cnt_q == CNT_W'(DEPTH));

endmodule

// File: rtl/fa_chan_mem.sv
module fa_chan_mem #(
    parameter int CHANNELS = 4,
    parameter int WORDS    = 256,
    parameter int DATA_W   = 32
) (
    input  logic                        clk,
    input  logic                        we,
    input  logic [$clog2(CHANNELS)-1:0] wchan,
    input  logic [$clog2(WORDS)-1:0]    waddr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [$clog2(CHANNELS)-1:0] rchan,
    input  logic [$clog2(WORDS)-1:0]    raddr,
    output logic [DATA_W-1:0]           rdata
);
    localparam int CH_W  = $clog2(CHANNELS);
    localparam int WA_W  = $clog2(WORDS);
    localparam int TOTAL = CHANNELS * WORDS;

    logic [DATA_W-1:0] store_q [TOTAL];

    logic [CH_W+WA_W-1:0] widx, ridx;
    assign widx = {wchan, waddr};
    assign ridx = {rchan, raddr};

    always_ff @(posedge clk) begin
        if (we) store_q[widx] <= wdata;
    end

    assign rdata = store_q[ridx];

endmodule

// File: rtl/fa_pkt_counters.sv
module fa_pkt_counters #(
    parameter int CHANNELS = 4,
    parameter int CNT_W    = 64
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        inc,
    input  logic [$clog2(CHANNELS)-1:0] inc_chan,
    output logic [CHANNELS*CNT_W-1:0]   cnt_flat
);
    localparam int CH_W = $clog2(CHANNELS);

    logic [CNT_W-1:0] cnt_q [CHANNELS];

    always_ff @(posedge clk) begin
        for (int c = 0; c < CHANNELS; c++) begin
            if (rst)
                cnt_q[c] <= '0;
            else if (inc && inc_chan == CH_W'(c))
                cnt_q[c] <= cnt_q[c] + 1'b1;
        end
    end

    for (genvar g = 0; g < CHANNELS; g++) begin : g_out
        assign cnt_flat[g*CNT_W +: CNT_W] = cnt_q[g];

        // R10: one step per delivered end beat of this channel
        a_r10_count_step: assert property (@(posedge clk) disable iff (rst)
            inc && inc_chan == CH_W'(g) |=> cnt_q[g] == $past(cnt_q[g]) + 1'b1);

        // R10: no change in any other cycle
        a_r10_count_hold: assert property (@(posedge clk) disable iff (rst)
            !(inc && inc_chan == CH_W'(g)) |=> $stable(cnt_q[g]));
    end

endmodule

// File: rtl/chan_frame_assembler.sv
module chan_frame_assembler
    import frame_asm_pkg::*;
#(
    parameter int CHANNELS   = 4,
    parameter int DATA_W     = 32,
    parameter int PTR_W      = 10,
    parameter int MAX_BYTES  = 1024,
    parameter int META_W     = 24,
    parameter int CNT_W      = 64,
    parameter int FIFO_DEPTH = 4,
    localparam int CH_W      = $clog2(CHANNELS),
    localparam int WB        = DATA_W / 8,
    localparam int WBW       = $clog2(WB),
    localparam int SIZE_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_valid,
    input  logic                      wr_is_write,
    input  logic [CH_W-1:0]           wr_chan,
    input  logic [PTR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      dsc_valid,
    output logic                      dsc_ready,
    input  logic [CH_W-1:0]           dsc_chan,
    input  logic [PTR_W-1:0]          dsc_addr,
    input  logic [SIZE_W-1:0]         dsc_size,
    input  logic [META_W-1:0]         dsc_meta,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [DATA_W-1:0]         out_data,
    output logic                      out_sof,
    output logic                      out_eof,
    output logic [WBW-1:0]            out_eof_pos,
    output logic [SIZE_W-1:0]         out_size,
    output logic [CH_W-1:0]           out_chan,
    output logic [META_W-1:0]         out_meta,
    output logic                      err_sticky,
    output logic [CHANNELS*CNT_W-1:0] pkt_cnt
);
    localparam int WA_W  = PTR_W - WBW;
    localparam int WORDS = 2 ** WA_W;
    localparam int DSC_W = CH_W + PTR_W + SIZE_W + META_W;

    typedef struct packed {
        eng_state_e        st;
        logic [CH_W-1:0]   chan;
        logic [WA_W-1:0]   ptr;
        logic [SIZE_W-1:0] remain;
        logic              first;
        logic [SIZE_W-1:0] csize;
        logic [META_W-1:0] cmeta;
        logic              err;
        logic              ov;
        logic [DATA_W-1:0] od;
        logic              osof;
        logic              oeof;
        logic [WBW-1:0]    opos;
        logic [SIZE_W-1:0] osize;
        logic [CH_W-1:0]   ochan;
        logic [META_W-1:0] ometa;
    } eng_t;

    eng_t eng_d, eng_q;

    // Descriptor queue
    logic              f_full, f_empty, f_pop;
    logic [DSC_W-1:0]  f_dout;
    logic [CH_W-1:0]   f_chan;
    logic [PTR_W-1:0]  f_addr;
    logic [SIZE_W-1:0] f_size;
    logic [META_W-1:0] f_meta;

    fa_desc_fifo #(.WIDTH(DSC_W), .DEPTH(FIFO_DEPTH)) u_dfifo (
        .clk   (clk),
        .rst   (rst),
        .push  (dsc_valid),
        .din   ({dsc_chan, dsc_addr, dsc_size, dsc_meta}),
        .pop   (f_pop),
        .dout  (f_dout),
        .full  (f_full),
        .empty (f_empty)
    );

    assign {f_chan, f_addr, f_size, f_meta} = f_dout;
    assign dsc_ready = !f_full;

    // Channel buffers
    logic [DATA_W-1:0] mem_rdata;

    fa_chan_mem #(.CHANNELS(CHANNELS), .WORDS(WORDS), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .we    (wr_valid && wr_is_write),
        .wchan (wr_chan),
        .waddr (wr_addr[PTR_W-1:WBW]),
        .wdata (wr_data),
        .rchan (eng_q.chan),
        .raddr (eng_q.ptr),
        .rdata (mem_rdata)
    );

    logic unused_low_bits;
    assign unused_low_bits = ^{wr_addr[WBW-1:0], f_addr[WBW-1:0]};

    // Next-state logic of the read engine and output register
    logic slot_free, last_beat;

    always_comb begin
        eng_d     = eng_q;
        f_pop     = 1'b0;
        slot_free = !eng_q.ov || out_ready;
        last_beat = (eng_q.remain <= SIZE_W'(WB));

        if (eng_q.ov && out_ready) eng_d.ov = 1'b0;

        case (eng_q.st)
            ENG_IDLE: begin
                // wait until the previous frame's end beat has left
                if (!f_empty && !eng_q.ov) begin
                    f_pop = 1'b1;
                    if (f_size == '0 || f_size > SIZE_W'(MAX_BYTES)) begin
                        eng_d.err = 1'b1;
                    end else begin
                        eng_d.st     = ENG_RUN;
                        eng_d.chan   = f_chan;
                        eng_d.ptr    = f_addr[PTR_W-1:WBW];
                        eng_d.remain = f_size;
                        eng_d.first  = 1'b1;
                        eng_d.csize  = f_size;
                        eng_d.cmeta  = f_meta;
                    end
                end
            end
            ENG_RUN: begin
                if (slot_free) begin
                    eng_d.ov   = 1'b1;
                    eng_d.od   = mem_rdata;
                    eng_d.osof = eng_q.first;
                    eng_d.oeof = last_beat;
                    eng_d.opos = last_beat ? WBW'(eng_q.remain - 1'b1) : '1;
                    if (eng_q.first) begin
                        eng_d.osize = eng_q.csize;
                        eng_d.ochan = eng_q.chan;
                        eng_d.ometa = eng_q.cmeta;
                    end
                    eng_d.ptr    = eng_q.ptr + 1'b1;
                    eng_d.remain = eng_q.remain - SIZE_W'(WB);
                    eng_d.first  = 1'b0;
                    if (last_beat) eng_d.st = ENG_IDLE;
                end
            end
            default: eng_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign out_valid   = eng_q.ov;
    assign out_data    = eng_q.od;
    assign out_sof     = eng_q.osof;
    assign out_eof     = eng_q.oeof;
    assign out_eof_pos = eng_q.opos;
    assign out_size    = eng_q.osize;
    assign out_chan    = eng_q.ochan;
    assign out_meta    = eng_q.ometa;
    assign err_sticky  = eng_q.err;

    // Packet statistics
    fa_pkt_counters #(.CHANNELS(CHANNELS), .CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .inc      (out_valid && out_ready && out_eof),
        .inc_chan (out_chan),
        .cnt_flat (pkt_cnt)
    );

    // Observer of frame boundaries at the output port
    logic              mon_in_frame_q;
    logic [SIZE_W-1:0] mon_size_q;
    logic [CH_W-1:0]   mon_chan_q;
    logic [META_W-1:0] mon_meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mon_in_frame_q <= 1'b0;
            mon_size_q     <= '0;
            mon_chan_q     <= '0;
            mon_meta_q     <= '0;
        end else if (out_valid && out_ready) begin
            mon_in_frame_q <= !out_eof;
            if (out_sof) begin
                mon_size_q <= out_size;
                mon_chan_q <= out_chan;
                mon_meta_q <= out_meta;
            end
        end
    end

    // R5: beat held while stalled
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof)
            && $stable(out_eof) && $stable(out_eof_pos) && $stable(out_size)
            && $stable(out_chan) && $stable(out_meta));

    // R6: start marker exactly when no frame is open
    a_r6_sof_framing: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_sof == !mon_in_frame_q));

    // R4: sideband constant across the beats of one frame
    a_r4_sideband_steady: assert property (@(posedge clk) disable iff (rst)
        out_valid && mon_in_frame_q |-> out_size == mon_size_q
            && out_chan == mon_chan_q && out_meta == mon_meta_q);

    // R9: error flag never clears
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_sticky |=> err_sticky);

    // R3: end position lies inside the declared length on a single-beat frame
    a_r3_single_beat_pos: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_sof && out_eof |-> SIZE_W'(out_eof_pos) == out_size - 1'b1);

endmodule

// File: tb/chan_frame_assembler_tb_top.sv
module chan_frame_assembler_tb_top;

    localparam int CH_W   = 2;
    localparam int PTR_W  = 10;
    localparam int SIZE_W = 11;
    localparam int META_W = 24;
    localparam int CNT_W  = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_valid = 1'b0, wr_is_write = 1'b0;
    logic [CH_W-1:0]   wr_chan = '0;
    logic [PTR_W-1:0]  wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic              dsc_valid = 1'b0, dsc_ready;
    logic [CH_W-1:0]   dsc_chan = '0;
    logic [PTR_W-1:0]  dsc_addr = '0;
    logic [SIZE_W-1:0] dsc_size = '0;
    logic [META_W-1:0] dsc_meta = '0;
    logic              out_valid, out_ready = 1'b1;
    logic [31:0]       out_data;
    logic              out_sof, out_eof;
    logic [1:0]        out_eof_pos;
    logic [SIZE_W-1:0] out_size;
    logic [CH_W-1:0]   out_chan;
    logic [META_W-1:0] out_meta;
    logic              err_sticky;
    logic [4*CNT_W-1:0] pkt_cnt;

    always #10 clk = ~clk;

    chan_frame_assembler dut_i (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_is_write(wr_is_write), .wr_chan(wr_chan),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .dsc_valid(dsc_valid), .dsc_ready(dsc_ready), .dsc_chan(dsc_chan),
        .dsc_addr(dsc_addr), .dsc_size(dsc_size), .dsc_meta(dsc_meta),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof), .out_eof_pos(out_eof_pos),
        .out_size(out_size), .out_chan(out_chan), .out_meta(out_meta),
        .err_sticky(err_sticky), .pkt_cnt(pkt_cnt)
    );

    typedef struct {
        logic [31:0]       d;
        logic              sof, eof;
        logic [1:0]        pos;
        logic [SIZE_W-1:0] size;
        logic [CH_W-1:0]   ch;
        logic [META_W-1:0] meta;
    } beat_t;

    beat_t       cap[$];
    int          n_chk = 0, n_fail = 0;
    int          rmode = 0;      // 0 ready, 1 pattern, 2 stalled
    int          tally[4] = '{0, 0, 0, 0};
    int          stall_seen = 0, stall_bad = 0;
    logic [31:0] exp_w[16];
    bit          done = 1'b0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // ready driver
    initial begin
        int cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            out_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? (cyc % 3 != 0) : 1'b0;
        end
    end

    // output monitor, sampling mid-low-phase
    initial begin
        beat_t p;
        bit    prev_stall = 1'b0;
        forever begin
            @(negedge clk);
            #5;
            if (!rst) begin
                if (prev_stall) begin
                    stall_seen++;
                    if (!out_valid || out_data != p.d || out_sof != p.sof || out_eof != p.eof
                        || out_eof_pos != p.pos || out_meta != p.meta)
                        stall_bad++;
                end
                p = '{out_data, out_sof, out_eof, out_eof_pos, out_size, out_chan, out_meta};
                prev_stall = out_valid && !out_ready;
                if (out_valid && out_ready) cap.push_back(p);
            end
        end
    end

    task automatic wr(input int ch, input int addr, input logic [31:0] d, input bit isw);
        @(negedge clk);
        wr_valid = 1'b1; wr_is_write = isw; wr_chan = CH_W'(ch);
        wr_addr = PTR_W'(addr); wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic post(input int ch, input int addr, input int sz, input int meta);
        @(negedge clk);
        dsc_valid = 1'b1; dsc_chan = CH_W'(ch); dsc_addr = PTR_W'(addr);
        dsc_size = SIZE_W'(sz); dsc_meta = META_W'(meta);
        while (!dsc_ready) @(negedge clk);
        @(negedge clk);
        dsc_valid = 1'b0;
    endtask

    task automatic check_frame(input int ch, input int sz, input int meta, input string rq);
        int nb = (sz + 3) / 4;
        int t = 0;
        while (cap.size() < nb && t < 3000) begin @(negedge clk); t++; end
        chk(cap.size() >= nb, rq, "beat count", cap.size(), nb);
        if (cap.size() < nb) return;
        for (int i = 0; i < nb; i++) begin
            beat_t b = cap.pop_front();
            chk(b.d == exp_w[i], rq, $sformatf("data beat %0d", i), b.d, exp_w[i]);
            chk(b.sof == (i == 0), "R3", $sformatf("sof beat %0d", i), b.sof, i == 0);
            chk(b.eof == (i == nb - 1), "R3", $sformatf("eof beat %0d", i), b.eof, i == nb - 1);
            chk(b.size == SIZE_W'(sz) && b.ch == CH_W'(ch) && b.meta == META_W'(meta), "R4",
                "sideband", {b.size, b.ch, b.meta}, {SIZE_W'(sz), CH_W'(ch), META_W'(meta)});
            if (i == nb - 1)
                chk(b.pos == 2'((sz - 1) % 4), "R3", "eof_pos", b.pos, (sz - 1) % 4);
        end
        tally[ch]++;
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
        chk(err_sticky == 1'b0, "R1", "err_sticky", err_sticky, 0);
        chk(dsc_ready == 1'b1, "R1", "dsc_ready", dsc_ready, 1);
        chk(pkt_cnt == '0, "R1", "counters", pkt_cnt[63:0], 0);
    endtask

    task automatic t_scattered();
        int order[5] = '{3, 0, 4, 1, 2};
        for (int i = 0; i < 5; i++) exp_w[i] = 32'h1100_0000 + 32'(i * 32'h0101);
        foreach (order[k]) wr(1, 'h40 + order[k] * 4, exp_w[order[k]], 1'b1);
        post(1, 'h40, 18, 'hABCDEF);
        check_frame(1, 18, 'hABCDEF, "R2");
    endtask

    task automatic t_backpressure();
        for (int i = 0; i < 3; i++) wr(2, 'h80 + i * 4, 32'hB000_0000 + 32'(i), 1'b1);
        for (int i = 0; i < 2; i++) wr(3, 'h20 + i * 4, 32'hC000_0000 + 32'(i), 1'b1);
        stall_seen = 0; stall_bad = 0;
        rmode = 1;
        post(2, 'h80, 12, 'h222);
        post(3, 'h20, 5, 'h333);
        for (int i = 0; i < 3; i++) exp_w[i] = 32'hB000_0000 + 32'(i);
        check_frame(2, 12, 'h222, "R6");
        for (int i = 0; i < 2; i++) exp_w[i] = 32'hC000_0000 + 32'(i);
        check_frame(3, 5, 'h333, "R6");
        rmode = 0;
        chk(stall_seen > 0 && stall_bad == 0, "R5", "stall stability", stall_bad, 0);
    endtask

    task automatic t_wrap();
        int a[4] = '{1016, 1020, 0, 4};
        for (int i = 0; i < 4; i++) begin
            exp_w[i] = 32'hD00D_0000 + 32'(i);
            wr(0, a[i], exp_w[i], 1'b1);
        end
        post(0, 1016, 16, 'h777);
        check_frame(0, 16, 'h777, "R7");
    endtask

    task automatic t_read_ignored();
        wr(0, 'h100, 32'hAAAA_5555, 1'b1);
        wr(0, 'h100, 32'h1234_5678, 1'b0);
        exp_w[0] = 32'hAAAA_5555;
        post(0, 'h100, 4, 'h88);
        check_frame(0, 4, 'h88, "R8");
    endtask

    task automatic t_isolation();
        wr(2, 'h200, 32'h2222_2222, 1'b1);
        wr(3, 'h200, 32'h3333_3333, 1'b1);
        exp_w[0] = 32'h2222_2222;
        post(2, 'h200, 3, 'h99);
        check_frame(2, 3, 'h99, "R11");
    endtask

    task automatic t_fifo_full();
        int  acc = 0;
        bit  broke = 1'b0;
        wr(0, 'h300, 32'h5A5A_0000, 1'b1);
        rmode = 2;
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (!dsc_ready) begin broke = 1'b1; break; end
            dsc_valid = 1'b1; dsc_chan = '0; dsc_addr = 'h300;
            dsc_size = 4; dsc_meta = META_W'(k);
            acc++;
        end
        if (!broke) @(negedge clk);
        dsc_valid = 1'b0;
        chk(broke, "R12", "dsc_ready low when full", broke, 1);
        chk(acc == 5, "R12", "accepted while stalled", acc, 5);
        rmode = 0;
        exp_w[0] = 32'h5A5A_0000;
        for (int k = 0; k < 5; k++) check_frame(0, 4, k, "R6");
    endtask

    task automatic t_bad_size();
        chk(err_sticky == 1'b0, "R9", "err before", err_sticky, 0);
        post(1, 0, 0, 'h1);
        post(1, 0, 1025, 'h2);
        repeat (20) @(negedge clk);
        chk(cap.size() == 0 && !out_valid, "R9", "no output for bad size", cap.size(), 0);
        chk(err_sticky == 1'b1, "R9", "err set", err_sticky, 1);
        wr(1, 'h10, 32'hFEED_BEEF, 1'b1);
        exp_w[0] = 32'hFEED_BEEF;
        post(1, 'h10, 2, 'h3);
        check_frame(1, 2, 'h3, "R9");
        chk(err_sticky == 1'b1, "R9", "err stays", err_sticky, 1);
    endtask

    task automatic t_counters();
        repeat (4) @(negedge clk);
        for (int c = 0; c < 4; c++)
            chk(pkt_cnt[c*CNT_W +: CNT_W] == CNT_W'(tally[c]), "R10",
                $sformatf("count ch%0d", c), pkt_cnt[c*CNT_W +: CNT_W], tally[c]);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_scattered();
        t_backpressure();
        t_wrap();
        t_read_ignored();
        t_isolation();
        t_fifo_full();
        t_bad_size();
        t_counters();
        finish_run();
    end

endmodule